// File: doc/BRIEF.md
# Warm-Reset Sequencer

This block gives a clean warm restart to an 8-bit processor that sits on a static RAM and takes its clock from the surrounding logic. A plain reset pulse can land in the middle of a write and corrupt memory. The sequencer avoids that. It takes the processor clock away from the free-running source and steps it one full period at a time. It watches the active-low bus strobes until it sees a memory read, which is a read with the I/O request strobe high. At that point it holds I/O request low to stall the processor and captures the byte the RAM is returning.

Next it forces read and write low together, which the processor treats as a reset request. While that happens it drives the captured byte back onto the data bus, so the write that the RAM performs stores the value it already held. After the required number of forced steps, once memory request reads high, every override is released and a one-cycle done pulse is given.

If no memory read turns up within a bounded number of steps, the block pulses the hard reset line instead. It does the same if memory request never returns high. A status bit records which of the two paths was taken. The block is started with a one-cycle pulse on `start_i`. There is no streaming data interface, so every pin is a plain control or status level.

Top module: `wrst_seq`

## Requirements
- R1: After reset the free clock enable is 1, the manual clock is 0, all overrides, hard reset and done are 0, and path_o is 0.
- R2: After start, the free clock enable is 0 while manual steps are issued. Each step holds cpu_clk_o high for exactly HALF system clocks (default 2) and then low for at least HALF.
- R3: A step that shows rd_n_i low with iorq_n_i low is an I/O cycle. It does not stall the processor, and the search continues with further steps.
- R4: When a step shows rd_n_i low with iorq_n_i high, iorq_force_o goes to 1 before the next manual clock rise and stays at 1 for every later forced step.
- R5: data_oe_o is 1 only while rd_force_o and wr_force_o are both 1, and data_o then equals the byte that was on data_i during the confirmed memory read.
- R6: The data driver is enabled while cpu_clk_o is low, and it is already on at the first manual clock rise after the capture.
- R7: With read and write forced, at least FLUSH (default 3) steps are issued. Stepping continues while mreq_n_i is low. When it reads high, all overrides drop and done_o pulses for one cycle with path_o = 0.
- R8: If TIMEOUT (default 256) steps pass without a memory read, hard_reset_o is 1 for HARD_CYC (default 8) cycles with no override active, and done_o then pulses with path_o = 1.
- R9: path_o keeps its value from a done pulse until the next start, and a start clears it to 0.
- R10: If mreq_n_i is still low after FLUSH+TIMEOUT forced steps, the hard reset path of R8 is taken with path_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a warm reset; honoured only while idle |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| path_o | output | 1 | 0 = clean write-back path, 1 = hard reset path |
| free_clk_en_o | output | 1 | Enables the free-running processor clock |
| cpu_clk_o | output | 1 | Manual single-step processor clock |
| rd_n_i | input | 1 | Processor read strobe, active low, asynchronous |
| iorq_n_i | input | 1 | Processor I/O request strobe, active low, asynchronous |
| mreq_n_i | input | 1 | Processor memory request strobe, active low, asynchronous |
| data_i | input | DW | Data bus as seen by the sequencer |
| iorq_force_o | output | 1 | Pull the I/O request line low (stall) |
| rd_force_o | output | 1 | Pull the read line low |
| wr_force_o | output | 1 | Pull the write line low |
| data_oe_o | output | 1 | Enable the sequencer's data bus driver |
| data_o | output | DW | Byte driven back during write-back |
| hard_reset_o | output | 1 | Direct processor reset pulse |

## Verification
The bus model answers each manual clock rise from a script, and four patterns are run against it. In the first, a memory read follows a few idle steps. The second places I/O reads before the memory read, which shows whether a low read strobe alone is enough to trigger the stall or whether I/O request is also examined. In the third, the read strobe never goes low, which exercises the search timeout and the hard reset pulse. In the fourth, memory request never returns high, which exercises the second bound. The model also releases memory request after either three or five forced steps, which shows that the release follows the strobe and not a fixed count.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SEARCH,
    S_STALL,
    S_DRIVE,
    S_FLUSH,
    S_HARD,
    S_FIN
  } wrst_state_e;
endpackage

// File: rtl/wrst_sync.sv
module wrst_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wrst_step.sv
// Emits one full manual clock period per accepted request:
// HALF cycles high, HALF cycles low, then a one-cycle fin pulse.
module wrst_step #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic sclk,
  output logic busy,
  output logic fin
);
  localparam int HW = $clog2(HALF + 1);
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b0;
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1;
          sclk <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt == LAST) begin
        cnt <= '0;
        if (sclk) begin
          sclk <= 1'b0;
        end else begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrst_cnt.sv
module wrst_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/wrst_seq.sv
module wrst_seq
  import wrst_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF     = 2,
  parameter int SYNC     = 2,
  parameter int TIMEOUT  = 256,
  parameter int FLUSH    = 3,
  parameter int HARD_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          done_o,
  output logic          path_o,
  output logic          free_clk_en_o,
  output logic          cpu_clk_o,
  input  logic          rd_n_i,
  input  logic          iorq_n_i,
  input  logic          mreq_n_i,
  input  logic [DW-1:0] data_i,
  output logic          iorq_force_o,
  output logic          rd_force_o,
  output logic          wr_force_o,
  output logic          data_oe_o,
  output logic [DW-1:0] data_o,
  output logic          hard_reset_o
);
  localparam int SW  = DW + 3;
  localparam int TW  = $clog2(FLUSH + TIMEOUT + 1);
  localparam int HCW = $clog2(HARD_CYC + 1);
  localparam logic [TW-1:0]  SRCH_LAST = TW'(TIMEOUT - 1);
  localparam logic [TW-1:0]  FL_MIN    = TW'(FLUSH - 1);
  localparam logic [TW-1:0]  FL_MAX    = TW'(FLUSH + TIMEOUT - 1);
  localparam logic [HCW-1:0] HR_LAST   = HCW'(HARD_CYC - 1);

  wrst_state_e state_q, state_d;

  // bus strobes and data brought into the system clock domain
  logic [SW-1:0] bus_s;
  logic          rd_s, iorq_s, mreq_s;
  logic [DW-1:0] data_s;

  wrst_sync #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rd_n_i, iorq_n_i, mreq_n_i, data_i}),
    .q     (bus_s)
  );
  assign {rd_s, iorq_s, mreq_s, data_s} = bus_s;

  // manual clock stepper
  logic step_go, step_clk, step_busy, step_fin;
  assign step_go = ((state_q == S_SEARCH) || (state_q == S_FLUSH)) && !step_busy && !step_fin;

  wrst_step #(.HALF(HALF)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (step_go),
    .sclk  (step_clk),
    .busy  (step_busy),
    .fin   (step_fin)
  );

  // step counters and hard reset pulse counter
  logic [TW-1:0]  srch_q, fls_q;
  logic [HCW-1:0] hr_q;

  wrst_cnt #(.W(TW)) u_srch_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != S_SEARCH),
    .inc   (step_fin),
    .q     (srch_q)
  );

  wrst_cnt #(.W(TW)) u_fls_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != S_FLUSH),
    .inc   (step_fin),
    .q     (fls_q)
  );

  wrst_cnt #(.W(HCW)) u_hr_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != S_HARD),
    .inc   (1'b1),
    .q     (hr_q)
  );

  // captured byte for write-back
  logic [DW-1:0] cap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cap_q <= '0;
    else if (state_q == S_STALL) cap_q <= data_s;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_SEARCH;
      S_SEARCH: if (step_fin) begin
                  if (!rd_s && iorq_s)        state_d = S_STALL;
                  else if (srch_q == SRCH_LAST) state_d = S_HARD;
                end
      S_STALL:  state_d = S_DRIVE;
      S_DRIVE:  state_d = S_FLUSH;
      S_FLUSH:  if (step_fin) begin
                  if ((fls_q >= FL_MIN) && mreq_s) state_d = S_FIN;
                  else if (fls_q >= FL_MAX)        state_d = S_HARD;
                end
      S_HARD:   if (hr_q == HR_LAST) state_d = S_FIN;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  logic path_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              path_q <= 1'b0;
    else if ((state_q == S_IDLE) && start_i) path_q <= 1'b0;
    else if (state_q == S_HARD)              path_q <= 1'b1;
  end

  logic wb_win;
  assign wb_win = (state_q == S_DRIVE) || (state_q == S_FLUSH);

  assign free_clk_en_o = (state_q == S_IDLE) || (state_q == S_HARD);
  assign cpu_clk_o     = step_clk;
  assign iorq_force_o  = wb_win || (state_q == S_STALL);
  assign rd_force_o    = wb_win;
  assign wr_force_o    = wb_win;
  assign data_oe_o     = wb_win;
  assign data_o        = cap_q;
  assign hard_reset_o  = (state_q == S_HARD);
  assign done_o        = (state_q == S_FIN);
  assign path_o        = path_q;
endmodule

// File: rtl/wrst_seq_chk.sv
module wrst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic free_clk_en_o,
  input logic cpu_clk_o,
  input logic iorq_force_o,
  input logic rd_force_o,
  input logic wr_force_o,
  input logic data_oe_o,
  input logic hard_reset_o,
  input logic done_o,
  input logic path_o
);
  a_r2_step_only_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_o |-> !free_clk_en_o);

  a_r4_stall_with_rw: assert property (@(posedge clk) disable iff (!rst_n)
    rd_force_o |-> iorq_force_o);

  a_r5_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (rd_force_o && wr_force_o));

  a_r6_drive_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> !cpu_clk_o);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_hard_no_override: assert property (@(posedge clk) disable iff (!rst_n)
    hard_reset_o |-> !(iorq_force_o || rd_force_o || wr_force_o || data_oe_o));

  a_r9_path_changes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(path_o) |-> ($past(start_i) || $past(hard_reset_o)));
endmodule

bind wrst_seq wrst_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .free_clk_en_o (free_clk_en_o),
  .cpu_clk_o     (cpu_clk_o),
  .iorq_force_o  (iorq_force_o),
  .rd_force_o    (rd_force_o),
  .wr_force_o    (wr_force_o),
  .data_oe_o     (data_oe_o),
  .hard_reset_o  (hard_reset_o),
  .done_o        (done_o),
  .path_o        (path_o)
);

// File: tb/wrst_seq_tb.sv
module wrst_seq_tb;
  localparam int HALF  = 2;
  localparam int TMO   = 256;
  localparam int FLUSH = 3;
  localparam int HARDC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, path_o, free_clk_en_o, cpu_clk_o;
  logic iorq_force_o, rd_force_o, wr_force_o, data_oe_o, hard_reset_o;
  logic [7:0] data_o;
  logic bus_rd = 1'b1, bus_io = 1'b1, bus_mq = 1'b1;
  logic [7:0] bus_d = 8'h00;

  always #5 clk = ~clk;

  wrst_seq u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .done_o (done_o), .path_o (path_o),
    .free_clk_en_o (free_clk_en_o), .cpu_clk_o (cpu_clk_o),
    .rd_n_i (bus_rd), .iorq_n_i (bus_io), .mreq_n_i (bus_mq), .data_i (bus_d),
    .iorq_force_o (iorq_force_o), .rd_force_o (rd_force_o), .wr_force_o (wr_force_o),
    .data_oe_o (data_oe_o), .data_o (data_o), .hard_reset_o (hard_reset_o)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural processor bus model: script item = {rd_n, iorq_n, mreq_n, data}
  logic [10:0] script[$];
  int  rst_need = 3, rst_cnt = 0;
  bit  mem_seen = 0;
  logic [7:0] exp_byte = 8'h00;
  int  search_edges = 0, forced_edges = 0, done_cnt = 0, last_path = 0;
  int  hi_len = 0, lo_len = 0, hr_len = 0, hr_last = 0;
  logic prev_clk = 1'b0;

  function automatic logic [10:0] item(input bit rd, input bit io, input bit mq, input logic [7:0] d);
    return {rd, io, mq, d};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_clk_o && !prev_clk) begin
        chk(lo_len >= HALF, "R2 low time before step", lo_len, HALF);
        if (!mem_seen) begin
          search_edges++;
          chk(!iorq_force_o, "R3 no stall before memory read", int'(iorq_force_o), 0);
        end else begin
          forced_edges++;
          chk(iorq_force_o, "R4 stall held at forced step", int'(iorq_force_o), 1);
          chk(data_oe_o && data_o == exp_byte, "R6 byte driven at forced step", int'(data_o), int'(exp_byte));
        end
        if (rd_force_o && wr_force_o) begin
          rst_cnt++;
          if (rst_cnt >= rst_need) begin bus_rd = 1; bus_io = 1; bus_mq = 1; end
        end else if (script.size() > 0) begin
          logic [10:0] it;
          it = script.pop_front();
          {bus_rd, bus_io, bus_mq, bus_d} = it;
          if (!it[10] && it[9]) begin mem_seen = 1; exp_byte = it[7:0]; end
        end else begin
          bus_rd = 1; bus_io = 1; bus_mq = 1;
        end
      end
      if (cpu_clk_o) begin
        hi_len++;
        lo_len = 0;
        chk(!free_clk_en_o, "R2 free clock off while stepping", int'(free_clk_en_o), 0);
      end else begin
        if (prev_clk) chk(hi_len == HALF, "R2 high time of step", hi_len, HALF);
        hi_len = 0;
        lo_len++;
      end
      if (data_oe_o)
        chk(rd_force_o && wr_force_o && data_o == exp_byte, "R5 driver only in write-back", int'(data_o), int'(exp_byte));
      if (hard_reset_o) hr_len++;
      else if (hr_len != 0) begin hr_last = hr_len; hr_len = 0; end
      if (done_o) begin done_cnt++; last_path = int'(path_o); end
      prev_clk = cpu_clk_o;
    end
  end

  task automatic run(input int need);
    int d0;
    rst_need = need; rst_cnt = 0; mem_seen = 0;
    search_edges = 0; forced_edges = 0; hr_last = 0;
    bus_rd = 1; bus_io = 1; bus_mq = 1;
    d0 = done_cnt;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(free_clk_en_o && !cpu_clk_o, "R1 idle clocks", int'(free_clk_en_o), 1);
    chk(!(iorq_force_o | rd_force_o | wr_force_o | data_oe_o), "R1 no overrides", int'(data_oe_o), 0);
    chk(!hard_reset_o && !done_o && !path_o, "R1 status idle", int'(path_o), 0);

    // memory read after idle steps, release after three forced steps
    script.push_back(item(1, 1, 0, 8'h00));
    script.push_back(item(0, 1, 0, 8'hA5));
    run(3);
    chk(last_path == 0, "R7 clean path", last_path, 0);
    chk(forced_edges == FLUSH, "R7 forced step count", forced_edges, FLUSH);
    chk(search_edges == 2, "R4 stall at first memory read", search_edges, 2);
    chk(!(rd_force_o | wr_force_o | iorq_force_o | data_oe_o), "R7 overrides released", int'(rd_force_o), 0);
    chk(bus_mq == 1'b1, "R7 memory request high at end", int'(bus_mq), 1);

    // no read ever: search timeout
    run(3);
    chk(last_path == 1, "R8 hard path", last_path, 1);
    chk(search_edges == TMO, "R8 steps before timeout", search_edges, TMO);
    chk(hr_last == HARDC, "R8 hard reset length", hr_last, HARDC);
    chk(forced_edges == 0, "R8 no forced steps", forced_edges, 0);
    repeat (30) @(negedge clk);
    chk(path_o == 1'b1, "R9 path held after done", int'(path_o), 1);

    // I/O reads skipped, release after five forced steps
    script.push_back(item(0, 0, 1, 8'h3C));
    script.push_back(item(0, 0, 1, 8'h3C));
    script.push_back(item(1, 1, 0, 8'h00));
    script.push_back(item(0, 1, 0, 8'h5A));
    run(5);
    chk(search_edges == 4, "R3 I/O reads skipped", search_edges, 4);
    chk(forced_edges == 5, "R7 steps follow memory request", forced_edges, 5);
    chk(last_path == 0 && path_o == 1'b0, "R9 path cleared by new start", int'(path_o), 0);

    // memory request never returns high
    script.push_back(item(0, 1, 0, 8'hC3));
    run(1000000);
    chk(last_path == 1, "R10 hard path after flush bound", last_path, 1);
    chk(forced_edges == FLUSH + TMO, "R10 forced step bound", forced_edges, FLUSH + TMO);
    chk(hr_last == HARDC, "R10 hard reset length", hr_last, HARDC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule